// File: doc/BRIEF.md
# Memory Operation Ordering Queue

This block keeps the in-flight memory operations of an out-of-order core in age order and decides, every cycle, which of them may go to the memory pipelines. Dispatch presents one operation per cycle as three flags (may read memory, may write memory, has side effects). The block turns them into one of five kinds: load, store, load fence, store fence or full fence. Each accepted operation takes one slot, and the slot number is returned as its tag.

Each cycle the block grants at most one load and at most one store: the oldest of each that the ordering rules allow. Stores always issue in program order with respect to every older load and store. Loads issue out of order with respect to other loads. A load may pass an older store only while the no-alias configuration input is high. Fences never issue. A fence completes by itself in the cycle it has become the oldest live entry, and until then it holds back the younger operations it covers. Loads and stores leave the queue when the memory pipeline reports their tag as complete.

Top module: `lsq_order_unit`

## Requirements
- R1: An allocation is accepted only if its class has room. Loads, load fences and full fences count against the load capacity. Stores and store fences count against the store capacity. The returned tag is the lowest-numbered free slot.
- R2: The flags map to kinds as follows. With side effects: read and write gives a full fence, read only gives a load fence, write only gives a store fence. Without side effects: any write gives a store, read only gives a load. A request that maps to no kind (neither read nor write) is refused.
- R3: A store is never granted while an older load or store has not yet been granted. This holds in both no-alias settings.
- R4: A load is not held back by older loads that are granted but not yet complete.
- R5: With `cfg_no_alias` high, a load may be granted while an older store is ungranted. With it low, the load waits until every older store has been granted.
- R6: A load waits for every older load fence and full fence. A store waits for every older store fence and full fence. A store fence does not hold back loads, and a load fence does not hold back stores.
- R7: A fence signals completion (`fence_done_valid` with its tag) only in a cycle in which no older entry is live. The slot is then freed.
- R8: Each cycle the block grants the oldest eligible load and the oldest eligible store. Each operation is granted exactly once, for one cycle.
- R9: A completion on `done_valid`/`done_tag` for a granted load or store frees its slot and returns its capacity.
- R10: A capacity parameter of 0 selects the default depth `DEF_DEPTH` (8).
- R11: After reset the queue is empty and nothing is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_no_alias | input | 1 | High: loads may pass older stores |
| alloc_valid | input | 1 | Allocation request |
| alloc_may_load | input | 1 | Operation may read memory |
| alloc_may_store | input | 1 | Operation may write memory |
| alloc_side_eff | input | 1 | Operation has side effects |
| alloc_accept | output | 1 | Request accepted this cycle |
| alloc_tag | output | TAGW | Slot given to the accepted operation |
| done_valid | input | 1 | A granted load or store has completed |
| done_tag | input | TAGW | Tag of the completed operation |
| ld_issue_valid | output | 1 | Load grant |
| ld_issue_tag | output | TAGW | Tag of the granted load |
| st_issue_valid | output | 1 | Store grant |
| st_issue_tag | output | TAGW | Tag of the granted store |
| fence_done_valid | output | 1 | A fence completed |
| fence_done_tag | output | TAGW | Tag of the completed fence |

## Verification
The hardest state to reach is one where several younger operations are held at once behind a fence or an ungranted store, and the hold is then lifted so that a load and a store are granted in the same cycle. The stimulus reaches it by leaving an early load incomplete, which pins a fence in place. It then queues loads and stores behind that fence and confirms that none of them is granted. Finally it completes the early load and checks the exact order in which the fence completion and the grants appear. The same idea, with the no-alias input toggled while a load is stuck behind an ungranted store, covers the alias switch.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

   typedef enum logic [2:0] {
      K_NONE  = 3'd0,
      K_LOAD  = 3'd1,
      K_STORE = 3'd2,
      K_LFNC  = 3'd3,
      K_SFNC  = 3'd4,
      K_FFNC  = 3'd5
   } op_kind_e;

   // flag triple -> operation kind
   function automatic op_kind_e classify(input logic rd, input logic wr, input logic se);
      op_kind_e k;
      if (se) begin
         if (rd && wr)  k = K_FFNC;
         else if (rd)   k = K_LFNC;
         else if (wr)   k = K_SFNC;
         else           k = K_NONE;
      end else if (wr) k = K_STORE;
      else if (rd)     k = K_LOAD;
      else             k = K_NONE;
      return k;
   endfunction

   function automatic logic on_load_side(input op_kind_e k);
      return (k == K_LOAD) || (k == K_LFNC) || (k == K_FFNC);
   endfunction

   function automatic logic is_fence(input op_kind_e k);
      return (k == K_LFNC) || (k == K_SFNC) || (k == K_FFNC);
   endfunction

endpackage

// File: rtl/lsq_free_find.sv
module lsq_free_find #(
   parameter int N  = 16,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  busy,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!busy[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/lsq_age_matrix.sv
module lsq_age_matrix #(
   parameter int N  = 16,
   parameter int IW = $clog2(N)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 alloc_en,
   input  logic [IW-1:0]        alloc_idx,
   input  logic [N-1:0]         live,
   output logic [N-1:0][N-1:0]  older
);
   // older[r][c] = 1 : slot c was allocated before slot r
   logic [N-1:0][N-1:0] age_q;
   logic [N-1:0]        new_bit;

   always_comb begin
      new_bit = '0;
      new_bit[alloc_idx] = 1'b1;
   end

   for (genvar r = 0; r < N; r++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            age_q[r] <= '0;
         end else if (alloc_en) begin
            if (alloc_idx == IW'(r)) age_q[r] <= live & ~new_bit;
            else                     age_q[r] <= age_q[r] & ~new_bit;
         end
      end
   end

   assign older = age_q;

   logic asym_bad;
   always_comb begin
      asym_bad = 1'b0;
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++)
            if (live[i] && live[j] && age_q[i][j] && age_q[j][i]) asym_bad = 1'b1;
   end

   p_age_antisym_r8: assert property (@(posedge clk) disable iff (!rst_n) !asym_bad)
      else $error("two live slots both claim to be older");
endmodule

// File: rtl/lsq_oldest_pick.sv
module lsq_oldest_pick #(
   parameter int N  = 16,
   parameter int IW = $clog2(N)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         elig,
   input  logic [N-1:0][N-1:0]  older,
   output logic                 gnt_valid,
   output logic [IW-1:0]        gnt_idx
);
   logic [N-1:0] hit;

   always_comb begin
      for (int i = 0; i < N; i++)
         hit[i] = elig[i] && !(|(older[i] & elig));
      gnt_valid = |hit;
      gnt_idx   = '0;
      for (int i = N - 1; i >= 0; i--)
         if (hit[i]) gnt_idx = IW'(i);
   end

   p_one_oldest_r8: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit))
      else $error("more than one oldest candidate");
   p_pick_present_r8: assert property (@(posedge clk) disable iff (!rst_n) (|elig) |-> gnt_valid)
      else $error("eligible entries but no grant");
endmodule

// File: rtl/lsq_order_unit.sv
module lsq_order_unit
   import lsq_pkg::*;
#(
   parameter int  LQ_DEPTH  = 0,
   parameter int  SQ_DEPTH  = 0,
   parameter int  DEF_DEPTH = 8,
   localparam int LQ_N = (LQ_DEPTH == 0) ? DEF_DEPTH : LQ_DEPTH,
   localparam int SQ_N = (SQ_DEPTH == 0) ? DEF_DEPTH : SQ_DEPTH,
   localparam int N    = LQ_N + SQ_N,
   localparam int TAGW = $clog2(N)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_no_alias,
   input  logic            alloc_valid,
   input  logic            alloc_may_load,
   input  logic            alloc_may_store,
   input  logic            alloc_side_eff,
   output logic            alloc_accept,
   output logic [TAGW-1:0] alloc_tag,
   input  logic            done_valid,
   input  logic [TAGW-1:0] done_tag,
   output logic            ld_issue_valid,
   output logic [TAGW-1:0] ld_issue_tag,
   output logic            st_issue_valid,
   output logic [TAGW-1:0] st_issue_tag,
   output logic            fence_done_valid,
   output logic [TAGW-1:0] fence_done_tag
);
   localparam int CW = $clog2(N + 1);

   if (DEF_DEPTH < 1 || LQ_N < 1 || SQ_N < 1) begin : g_bad_depth
      $error("queue depths must resolve to at least one entry");
   end
   if (N < 2) begin : g_bad_total
      $error("total slot count must be at least two");
   end

   // entry state
   logic [N-1:0]  valid_q, issued_q;
   op_kind_e      kind_q [N];
   logic [CW-1:0] lq_cnt_q, sq_cnt_q;

   // derived views
   logic [N-1:0][N-1:0] older;
   logic [N-1:0] pend_ld, pend_st, lfnc_v, sfnc_v, fnc_v, lq_cls, sq_cls;
   logic [N-1:0] ld_elig, st_elig, fnc_rdy;

   op_kind_e        alloc_kind;
   logic            alloc_lq, free_found;
   logic [TAGW-1:0] free_idx, done_idx;
   logic            done_hit;

   lsq_free_find #(.N(N), .IW(TAGW)) u_free (
      .busy (valid_q), .found (free_found), .idx (free_idx)
   );

   lsq_age_matrix #(.N(N), .IW(TAGW)) u_age (
      .clk (clk), .rst_n (rst_n), .alloc_en (alloc_accept),
      .alloc_idx (alloc_tag), .live (valid_q), .older (older)
   );

   always_comb begin
      alloc_kind   = classify(alloc_may_load, alloc_may_store, alloc_side_eff);
      alloc_lq     = on_load_side(alloc_kind);
      alloc_tag    = free_idx;
      alloc_accept = alloc_valid && (alloc_kind != K_NONE) && free_found &&
                     (alloc_lq ? (lq_cnt_q < CW'(LQ_N)) : (sq_cnt_q < CW'(SQ_N)));
   end

   always_comb begin
      for (int i = 0; i < N; i++) begin
         pend_ld[i] = valid_q[i] && (kind_q[i] == K_LOAD)  && !issued_q[i];
         pend_st[i] = valid_q[i] && (kind_q[i] == K_STORE) && !issued_q[i];
         lfnc_v[i]  = valid_q[i] && ((kind_q[i] == K_LFNC) || (kind_q[i] == K_FFNC));
         sfnc_v[i]  = valid_q[i] && ((kind_q[i] == K_SFNC) || (kind_q[i] == K_FFNC));
         fnc_v[i]   = valid_q[i] && is_fence(kind_q[i]);
         lq_cls[i]  = valid_q[i] && on_load_side(kind_q[i]);
         sq_cls[i]  = valid_q[i] && !on_load_side(kind_q[i]);
      end
   end

   always_comb begin
      for (int i = 0; i < N; i++) begin
         logic [N-1:0] ahead;
         ahead      = older[i] & valid_q;
         ld_elig[i] = pend_ld[i] && !(|(ahead & lfnc_v)) &&
                      (cfg_no_alias || !(|(ahead & pend_st)));
         st_elig[i] = pend_st[i] && !(|(ahead & (pend_ld | pend_st))) &&
                      !(|(ahead & sfnc_v));
         fnc_rdy[i] = fnc_v[i] && !(|ahead);
      end
   end

   lsq_oldest_pick #(.N(N), .IW(TAGW)) u_pick_ld (
      .clk (clk), .rst_n (rst_n), .elig (ld_elig), .older (older),
      .gnt_valid (ld_issue_valid), .gnt_idx (ld_issue_tag)
   );
   lsq_oldest_pick #(.N(N), .IW(TAGW)) u_pick_st (
      .clk (clk), .rst_n (rst_n), .elig (st_elig), .older (older),
      .gnt_valid (st_issue_valid), .gnt_idx (st_issue_tag)
   );
   lsq_oldest_pick #(.N(N), .IW(TAGW)) u_pick_fnc (
      .clk (clk), .rst_n (rst_n), .elig (fnc_rdy), .older (older),
      .gnt_valid (fence_done_valid), .gnt_idx (fence_done_tag)
   );

   always_comb begin
      done_idx = (int'(done_tag) < N) ? done_tag : '0;
      done_hit = done_valid && (int'(done_tag) < N) && valid_q[done_idx] &&
                 issued_q[done_idx];
   end

   logic lq_dec_a, lq_dec_b, sq_dec_a, sq_dec_b;
   always_comb begin
      lq_dec_a = done_hit && (kind_q[done_idx] == K_LOAD);
      sq_dec_a = done_hit && (kind_q[done_idx] == K_STORE);
      lq_dec_b = fence_done_valid && on_load_side(kind_q[fence_done_tag]);
      sq_dec_b = fence_done_valid && !on_load_side(kind_q[fence_done_tag]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q  <= '0;
         issued_q <= '0;
         lq_cnt_q <= '0;
         sq_cnt_q <= '0;
         for (int i = 0; i < N; i++) kind_q[i] <= K_NONE;
      end else begin
         if (alloc_accept) begin
            valid_q[alloc_tag]  <= 1'b1;
            issued_q[alloc_tag] <= 1'b0;
            kind_q[alloc_tag]   <= alloc_kind;
         end
         if (ld_issue_valid)   issued_q[ld_issue_tag]   <= 1'b1;
         if (st_issue_valid)   issued_q[st_issue_tag]   <= 1'b1;
         if (done_hit)         valid_q[done_idx]        <= 1'b0;
         if (fence_done_valid) valid_q[fence_done_tag]  <= 1'b0;
         lq_cnt_q <= lq_cnt_q + CW'(alloc_accept && alloc_lq)
                              - CW'(lq_dec_a) - CW'(lq_dec_b);
         sq_cnt_q <= sq_cnt_q + CW'(alloc_accept && !alloc_lq)
                              - CW'(sq_dec_a) - CW'(sq_dec_b);
      end
   end

   // checks kept beside the state they guard
   p_lq_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(lq_cnt_q) == $countones(lq_cls)) && (int'(lq_cnt_q) <= LQ_N))
      else $error("load-side occupancy out of step");
   p_sq_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(sq_cnt_q) == $countones(sq_cls)) && (int'(sq_cnt_q) <= SQ_N))
      else $error("store-side occupancy out of step");
   p_ld_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ld_issue_valid |=> issued_q[$past(ld_issue_tag)])
      else $error("granted load not marked");
   p_st_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
      st_issue_valid |=> issued_q[$past(st_issue_tag)])
      else $error("granted store not marked");
   p_fence_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fence_done_valid |=> !valid_q[$past(fence_done_tag)])
      else $error("completed fence still live");
endmodule

// File: tb/tb_lsq_order_unit.sv
`timescale 1ns/1ps
module tb_lsq_order_unit;
   localparam int TW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_no_alias = 1'b1;
   logic alloc_valid = 1'b0, alloc_may_load = 1'b0, alloc_may_store = 1'b0, alloc_side_eff = 1'b0;
   logic alloc_accept;
   logic [TW-1:0] alloc_tag;
   logic done_valid = 1'b0;
   logic [TW-1:0] done_tag = '0;
   logic ld_issue_valid, st_issue_valid, fence_done_valid;
   logic [TW-1:0] ld_issue_tag, st_issue_tag, fence_done_tag;

   int checks = 0;
   int errors = 0;
   bit mon_on = 1'b0;
   int    exp_q[$];
   string req_q[$];

   always #4 clk = ~clk;

   // load capacity 0 -> default 8, store capacity 2: ten slots
   lsq_order_unit #(.LQ_DEPTH(0), .SQ_DEPTH(2), .DEF_DEPTH(8)) dut (
      .clk (clk), .rst_n (rst_n), .cfg_no_alias (cfg_no_alias),
      .alloc_valid (alloc_valid), .alloc_may_load (alloc_may_load),
      .alloc_may_store (alloc_may_store), .alloc_side_eff (alloc_side_eff),
      .alloc_accept (alloc_accept), .alloc_tag (alloc_tag),
      .done_valid (done_valid), .done_tag (done_tag),
      .ld_issue_valid (ld_issue_valid), .ld_issue_tag (ld_issue_tag),
      .st_issue_valid (st_issue_valid), .st_issue_tag (st_issue_tag),
      .fence_done_valid (fence_done_valid), .fence_done_tag (fence_done_tag)
   );

   // kind codes: 0 load grant, 1 store grant, 2 fence completion
   task automatic expect_ev(input int kind, input int tag, input string req);
      exp_q.push_back(kind * 256 + tag);
      req_q.push_back(req);
   endtask

   task automatic check_ev(input int kind, input int tag);
      int e;
      string r;
      checks++;
      if (exp_q.size() == 0) begin
         errors++;
         $display("FAIL R8 unexpected event kind %0d tag %0d, expected none", kind, tag);
      end else begin
         e = exp_q.pop_front();
         r = req_q.pop_front();
         if (e != kind * 256 + tag) begin
            errors++;
            $display("FAIL %s event kind %0d tag %0d, expected kind %0d tag %0d",
                     r, kind, tag, e / 256, e % 256);
         end
      end
   endtask

   // monitor: compares every observed event with the scoreboard queue
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (mon_on) begin
            if (ld_issue_valid)   check_ev(0, int'(ld_issue_tag));
            if (st_issue_valid)   check_ev(1, int'(st_issue_tag));
            if (fence_done_valid) check_ev(2, int'(fence_done_tag));
         end
      end
   end

   task automatic step(input bit av, input bit rd, input bit wr, input bit se,
                       input bit dv, input int dt,
                       input bit exp_acc, input int exp_tag, input string req);
      @(negedge clk);
      alloc_valid = av; alloc_may_load = rd; alloc_may_store = wr; alloc_side_eff = se;
      done_valid = dv; done_tag = TW'(dt);
      #1;
      checks++;
      if (alloc_accept !== exp_acc) begin
         errors++;
         $display("FAIL %s accept %0b expected %0b", req, alloc_accept, exp_acc);
      end
      if (exp_acc) begin
         checks++;
         if (alloc_tag !== TW'(exp_tag)) begin
            errors++;
            $display("FAIL %s tag %0d expected %0d", req, alloc_tag, exp_tag);
         end
      end
      @(posedge clk);
      #1;
      alloc_valid = 1'b0; alloc_may_load = 1'b0; alloc_may_store = 1'b0; alloc_side_eff = 1'b0;
      done_valid = 1'b0;
   endtask

   task automatic idle();                step(0, 0, 0, 0, 0, 0, 0, 0, "R8"); endtask
   task automatic put(input bit rd, input bit wr, input bit se, input int tag, input string req);
      step(1, rd, wr, se, 0, 0, 1, tag, req);
   endtask
   task automatic deny(input bit rd, input bit wr, input bit se, input string req);
      step(1, rd, wr, se, 0, 0, 0, 0, req);
   endtask
   task automatic free(input int tag);   step(0, 0, 0, 0, 1, tag, 0, 0, "R9"); endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      #1;
      checks++;
      if (ld_issue_valid || st_issue_valid || fence_done_valid || alloc_accept) begin
         errors++;
         $display("FAIL R11 outputs after reset %0b%0b%0b%0b expected 0000",
                  ld_issue_valid, st_issue_valid, fence_done_valid, alloc_accept);
      end
      mon_on = 1'b1;
      idle(); idle();

      // basic load: lowest free slot, granted once (R1 R2 R8)
      put(1, 0, 0, 0, "R1");
      expect_ev(0, 0, "R8");
      idle(); idle();
      free(0);

      // load fence pinned by an incomplete load (R6 R7 R3 R5)
      put(1, 0, 0, 0, "R1");  expect_ev(0, 0, "R8");
      put(1, 0, 1, 1, "R2");
      put(1, 0, 0, 2, "R1");
      put(0, 1, 0, 3, "R1");
      put(1, 0, 0, 4, "R1");
      idle();                               // all held: R6 / R3 / R7
      free(0);                 expect_ev(2, 1, "R7");
      idle();                  expect_ev(0, 2, "R6");
      idle();                  expect_ev(0, 4, "R5"); expect_ev(1, 3, "R3");
      idle();
      free(2); free(3); free(4);

      // store fence, alias switch off then on (R5 R6)
      cfg_no_alias = 1'b0;
      put(1, 0, 0, 0, "R1");  expect_ev(0, 0, "R8");
      put(0, 1, 1, 1, "R2");
      put(0, 1, 0, 2, "R1");
      put(1, 0, 0, 3, "R1");
      idle();                               // load waits on ungranted store: R5
      cfg_no_alias = 1'b1;     expect_ev(0, 3, "R5");
      idle();
      free(0);                 expect_ev(2, 1, "R7");
      idle();                  expect_ev(1, 2, "R6");
      idle();
      free(2); free(3);

      // full fence holds both classes (R6 R7)
      put(1, 0, 0, 0, "R1");  expect_ev(0, 0, "R8");
      put(1, 1, 1, 1, "R2");
      put(1, 0, 0, 2, "R1");
      put(0, 1, 0, 3, "R1");
      idle();
      free(0);                 expect_ev(2, 1, "R7");
      idle();                  expect_ev(0, 2, "R6");
      idle();                  expect_ev(1, 3, "R3");
      idle();
      free(2); free(3);

      // store capacity 2 (R1 R2 R9)
      put(0, 1, 0, 0, "R1");  expect_ev(1, 0, "R3");
      put(0, 1, 0, 1, "R1");  expect_ev(1, 1, "R3");
      deny(0, 1, 0, "R1");
      deny(0, 1, 1, "R1");
      deny(1, 1, 0, "R2");                  // read+write, no side effect: store class
      deny(0, 0, 0, "R2");
      deny(0, 0, 1, "R2");
      free(0);
      put(0, 1, 0, 0, "R9");  expect_ev(1, 0, "R9");
      idle();
      free(0); free(1);

      // load capacity defaults to 8 (R10 R4)
      for (int k = 0; k < 8; k++) begin
         put(1, 0, 0, k, "R10");
         expect_ev(0, k, "R4");
      end
      deny(1, 0, 0, "R10");
      deny(1, 0, 1, "R10");
      put(0, 1, 0, 8, "R1");  expect_ev(1, 8, "R3");
      idle();
      for (int k = 0; k < 9; k++) free(k);
      idle(); idle(); idle();

      while (exp_q.size() > 0) begin
         checks++;
         errors++;
         $display("FAIL %s missing event kind %0d tag %0d, expected it seen",
                  req_q.pop_front(), exp_q[0] / 256, exp_q[0] % 256);
         void'(exp_q.pop_front());
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog expired, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule